// File: doc/BRIEF.md
# Serial EEPROM Slave Command Engine

This block is the slave-side protocol engine of a serial EEPROM that speaks SPI in clock modes 0 and 3. It runs on a fast system clock. It passes the serial clock, the active-low select, the serial data input and the active-low pause input through two-flop synchronisers, and it finds the serial clock edges in the system clock domain. After each select falling edge the engine takes in an 8-bit command. Depending on that command it then takes a 16-bit address, streams bytes out of an internal byte array, or collects bytes for other units. Every field travels most significant bit first. The serial output is split into a data bit and an output enable; the pad tri-states the line whenever the enable is low.

The engine does not program anything itself. Each byte of an array write goes out on a request port, with its page-wrapped address. A commit pulse follows when select goes high. A status-write byte goes out on its own port, and the write-latch set and clear commands appear as single pulses. The units that receive these own the page buffer, the protection rules and the status register. They supply the status byte and a busy flag, and they write finished bytes back into the array through a simple write port.

Top module: `eeprom_cmd_engine`

## Requirements
- R1: Commands are recognised from the received byte with bit 3 ignored and bits 7..4 required to be zero. The low three bits select the command: 110 latch-set, 100 latch-clear, 101 status-read, 001 status-write, 011 array-read, 010 array-write.
- R2: A byte with a non-zero upper nibble, or with low bits 000 or 111, freezes the transfer. Until select falls again, the output enable stays low and no request, status-write or latch pulse is issued. The next transaction then works normally.
- R3: An array-read takes a 16-bit address, high byte first. It then returns the byte at that address and keeps returning following bytes as long as clocks continue. Only the low MEM_AW address bits index the array, so after the last location the address wraps to location 0.
- R4: A status-read drives the status_in byte on the output, MSB first. It repeats that byte, sampled afresh, for every further 8 clocks.
- R5: An array-write takes a 16-bit address. Each following full byte produces one wdat_valid pulse with that byte. The address carried by a pulse increments only in its low PAGE_W bits, wrapping within the page. When select rises after at least one such byte, exactly one wr_commit pulse is issued.
- R6: A status-write produces one sts_wr_valid pulse carrying the byte that follows the command. Later bytes in the same transaction are ignored.
- R7: The latch-set and latch-clear commands each produce exactly one pulse on wel_set or wel_clr. At most one of the five event outputs is high in any cycle.
- R8: When wr_busy is high as a command completes, every command except status-read is treated as in R2. Status-read still returns status_in.
- R9: The pause input takes effect only when it falls while the serial clock is low, and it releases only when it rises while the serial clock is low. While paused, the output enable is low and clock and data activity are ignored. After release the transfer resumes at the same bit position.
- R10: While select is high, the output enable is low, serial input is ignored and no event pulse is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Serial data into the engine |
| spi_hold_n | input | 1 | Active-low pause request |
| spi_miso | output | 1 | Serial data bit out |
| spi_miso_oe | output | 1 | Output enable for the serial data pad |
| wr_busy | input | 1 | Internal program cycle in progress |
| status_in | input | 8 | Status byte returned by status-read |
| wel_set | output | 1 | Pulse: write latch set command |
| wel_clr | output | 1 | Pulse: write latch clear command |
| wdat_valid | output | 1 | Pulse: one array-write byte received |
| wdat_addr | output | ADDR_W | Page-wrapped address of that byte |
| wdat_byte | output | 8 | Received array-write byte |
| wr_commit | output | 1 | Pulse: array-write transaction closed by select rising |
| sts_wr_valid | output | 1 | Pulse: status-write byte received |
| sts_wr_byte | output | 8 | Received status-write byte |
| arr_we | input | 1 | Array write strobe from the programming unit |
| arr_waddr | input | MEM_AW | Array write location |
| arr_wdata | input | 8 | Array write data |

## Verification
The bench builds the engine with the default ADDR_W of 16, MEM_AW of 8 and PAGE_W of 7. A 256-byte array lets reads cross the top of the array, with random upper address bits, within a few bytes. The 128-byte page lets a four-byte write starting near a page end show the low-bit wrap. Both serial clock modes are driven, and pauses are placed in the address and data phases.

// File: rtl/eeprom_cmd_pkg.sv
package eeprom_cmd_pkg;

    // low three bits of a command byte; bit 3 is a don't-care
    typedef enum logic [2:0] {
        OP_STATUS_WR = 3'b001,
        OP_ARRAY_WR  = 3'b010,
        OP_ARRAY_RD  = 3'b011,
        OP_LATCH_CLR = 3'b100,
        OP_STATUS_RD = 3'b101,
        OP_LATCH_SET = 3'b110
    } opcode_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_OPCODE,
        PH_ADDR,
        PH_RD_DATA,
        PH_WR_DATA,
        PH_STAT_OUT,
        PH_STAT_IN,
        PH_DONE,
        PH_FROZEN
    } phase_e;

    typedef struct packed {
        logic    ok;
        opcode_e op;
    } decode_t;

    typedef struct packed {
        logic sck;
        logic cs_n;
        logic si;
        logic hold_n;
    } pins_t;

    // idle levels of the synchronised pins: sck low, select high, data low, pause high
    localparam logic [3:0] PINS_IDLE = 4'b0101;

    function automatic decode_t decode_opcode(input logic [7:0] b);
        decode_t d;
        d.ok = (b[7:4] == 4'h0) && (b[2:0] != 3'b000) && (b[2:0] != 3'b111);
        d.op = opcode_e'(b[2:0]);
        return d;
    endfunction

endpackage

// File: rtl/pin_sync.sv
module pin_sync #(
    parameter int          W       = 4,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    for (genvar g = 0; g < W; g++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst) begin
                meta[g] <= RST_VAL[g];
                q[g]    <= RST_VAL[g];
            end else begin
                meta[g] <= d[g];
                q[g]    <= meta[g];
            end
        end
    end
endmodule

// File: rtl/hold_gate.sv
module hold_gate (
    input  logic clk,
    input  logic rst,
    input  logic cs_s,
    input  logic sck_s,
    input  logic hold_s,
    output logic held
);
    always_ff @(posedge clk) begin
        if (rst || cs_s) begin
            held <= 1'b0;
        end else if (!held && !hold_s && !sck_s) begin
            held <= 1'b1;
        end else if (held && hold_s && !sck_s) begin
            held <= 1'b0;
        end
    end

    // R9: a pause can only begin while the serial clock is low
    a_r9_engage_sck_low: assert property (@(posedge clk) disable iff (rst)
        $rose(held) |-> !$past(sck_s));

    // R9: a pause can only end while the serial clock is low
    a_r9_release_sck_low: assert property (@(posedge clk) disable iff (rst)
        ($fell(held) && !$past(cs_s)) |-> !$past(sck_s));
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array #(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] cells [0:DEPTH-1];

    always_ff @(posedge clk) begin
        if (we) cells[waddr] <= wdata;
    end

    assign rdata = cells[raddr];
endmodule

// File: rtl/eeprom_cmd_engine.sv
module eeprom_cmd_engine
    import eeprom_cmd_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int MEM_AW = 8,
    parameter int PAGE_W = 7
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              spi_sck,
    input  logic              spi_cs_n,
    input  logic              spi_mosi,
    input  logic              spi_hold_n,
    output logic              spi_miso,
    output logic              spi_miso_oe,
    input  logic              wr_busy,
    input  logic [7:0]        status_in,
    output logic              wel_set,
    output logic              wel_clr,
    output logic              wdat_valid,
    output logic [ADDR_W-1:0] wdat_addr,
    output logic [7:0]        wdat_byte,
    output logic              wr_commit,
    output logic              sts_wr_valid,
    output logic [7:0]        sts_wr_byte,
    input  logic              arr_we,
    input  logic [MEM_AW-1:0] arr_waddr,
    input  logic [7:0]        arr_wdata
);
    localparam int ADDR_BYTES = ADDR_W / 8;
    localparam int ABW        = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;
    localparam logic [ABW-1:0] ALAST = ABW'(ADDR_BYTES - 1);

    pins_t pin_raw, pin_s;
    logic  held;

    assign pin_raw = '{sck: spi_sck, cs_n: spi_cs_n, si: spi_mosi, hold_n: spi_hold_n};

    pin_sync #(.W(4), .RST_VAL(PINS_IDLE)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pin_raw),
        .q   (pin_s)
    );

    hold_gate u_hold (
        .clk    (clk),
        .rst    (rst),
        .cs_s   (pin_s.cs_n),
        .sck_s  (pin_s.sck),
        .hold_s (pin_s.hold_n),
        .held   (held)
    );

    phase_e            phase_q;
    logic [2:0]        bit_q;
    logic [7:0]        shift_q;
    logic [ADDR_W-1:0] addr_q;
    logic [ABW-1:0]    abyte_q;
    logic              is_rd_q;
    logic              wr_seen_q;
    logic [7:0]        out_q;
    logic              live_q;
    logic              miso_oe_q;
    logic              sck_q;
    logic              cs_q;
    logic [7:0]        rd_data;

    eeprom_cell_array #(.AW(MEM_AW), .DW(8)) u_array (
        .clk   (clk),
        .we    (arr_we),
        .waddr (arr_waddr),
        .wdata (arr_wdata),
        .raddr (addr_q[MEM_AW-1:0]),
        .rdata (rd_data)
    );

    logic [7:0] sh_next;
    decode_t    dec;
    logic       byte_done;
    logic       sck_rise;
    logic       sck_fall;
    logic       out_phase;

    always_comb begin
        sh_next   = {shift_q[6:0], pin_s.si};
        dec       = decode_opcode(sh_next);
        byte_done = (bit_q == 3'd7);
        sck_rise  = pin_s.sck && !sck_q;
        sck_fall  = !pin_s.sck && sck_q;
        out_phase = (phase_q == PH_RD_DATA) || (phase_q == PH_STAT_OUT);
    end

    always_ff @(posedge clk) begin
        wel_set      <= 1'b0;
        wel_clr      <= 1'b0;
        wdat_valid   <= 1'b0;
        sts_wr_valid <= 1'b0;
        wr_commit    <= 1'b0;
        if (rst) begin
            phase_q     <= PH_IDLE;
            bit_q       <= '0;
            shift_q     <= '0;
            addr_q      <= '0;
            abyte_q     <= '0;
            is_rd_q     <= 1'b0;
            wr_seen_q   <= 1'b0;
            out_q       <= '0;
            live_q      <= 1'b0;
            miso_oe_q   <= 1'b0;
            wdat_addr   <= '0;
            wdat_byte   <= '0;
            sts_wr_byte <= '0;
            sck_q       <= 1'b0;
            cs_q        <= 1'b1;
        end else begin
            sck_q <= pin_s.sck;
            cs_q  <= pin_s.cs_n;
            if (pin_s.cs_n) begin
                // deselected: close the transaction, commit a write with data
                if (!cs_q && phase_q == PH_WR_DATA && wr_seen_q) wr_commit <= 1'b1;
                phase_q   <= PH_IDLE;
                live_q    <= 1'b0;
                miso_oe_q <= 1'b0;
            end else if (cs_q) begin
                // select falling edge: fresh command
                phase_q   <= PH_OPCODE;
                bit_q     <= '0;
                abyte_q   <= '0;
                wr_seen_q <= 1'b0;
                live_q    <= 1'b0;
                miso_oe_q <= 1'b0;
            end else if (held) begin
                miso_oe_q <= 1'b0;
            end else begin
                miso_oe_q <= live_q;
                if (sck_rise && phase_q != PH_FROZEN && phase_q != PH_IDLE) begin
                    shift_q <= sh_next;
                    bit_q   <= bit_q + 3'd1;
                    if (byte_done) begin
                        case (phase_q)
                            PH_OPCODE: begin
                                if (!dec.ok || (wr_busy && dec.op != OP_STATUS_RD)) begin
                                    phase_q <= PH_FROZEN;
                                end else begin
                                    case (dec.op)
                                        OP_LATCH_SET: begin wel_set <= 1'b1; phase_q <= PH_DONE; end
                                        OP_LATCH_CLR: begin wel_clr <= 1'b1; phase_q <= PH_DONE; end
                                        OP_STATUS_RD: phase_q <= PH_STAT_OUT;
                                        OP_STATUS_WR: phase_q <= PH_STAT_IN;
                                        OP_ARRAY_RD:  begin is_rd_q <= 1'b1; phase_q <= PH_ADDR; end
                                        OP_ARRAY_WR:  begin is_rd_q <= 1'b0; phase_q <= PH_ADDR; end
                                        default:      phase_q <= PH_FROZEN;
                                    endcase
                                end
                            end
                            PH_ADDR: begin
                                addr_q <= ADDR_W'({addr_q, sh_next});
                                if (abyte_q == ALAST) begin
                                    phase_q <= is_rd_q ? PH_RD_DATA : PH_WR_DATA;
                                end else begin
                                    abyte_q <= abyte_q + 1'b1;
                                end
                            end
                            PH_WR_DATA: begin
                                wdat_valid           <= 1'b1;
                                wdat_byte            <= sh_next;
                                wdat_addr            <= addr_q;
                                addr_q[PAGE_W-1:0]   <= addr_q[PAGE_W-1:0] + 1'b1;
                                wr_seen_q            <= 1'b1;
                            end
                            PH_STAT_IN: begin
                                sts_wr_valid <= 1'b1;
                                sts_wr_byte  <= sh_next;
                                phase_q      <= PH_DONE;
                            end
                            default: ;
                        endcase
                    end
                end else if (sck_fall && out_phase) begin
                    if (bit_q == 3'd0) begin
                        out_q  <= (phase_q == PH_RD_DATA) ? rd_data : status_in;
                        live_q <= 1'b1;
                        if (phase_q == PH_RD_DATA) addr_q <= addr_q + 1'b1;
                    end else if (live_q) begin
                        out_q <= {out_q[6:0], 1'b0};
                    end
                end
            end
        end
    end

    assign spi_miso    = out_q[7];
    assign spi_miso_oe = miso_oe_q;

    // R10: deselect always leaves the output pad released
    a_r10_deselect_quiet: assert property (@(posedge clk) disable iff (rst)
        pin_s.cs_n |=> !spi_miso_oe);

    // R2: a frozen transfer neither drives the pad nor issues requests
    a_r2_frozen_silent: assert property (@(posedge clk) disable iff (rst)
        (phase_q == PH_FROZEN) |-> (!spi_miso_oe && !wdat_valid && !sts_wr_valid));

    // R7: event outputs are mutually exclusive
    a_r7_one_event: assert property (@(posedge clk) disable iff (rst)
        $onehot0({wel_set, wel_clr, wdat_valid, sts_wr_valid, wr_commit}));

    // R9: while paused the pad is released
    a_r9_held_quiet: assert property (@(posedge clk) disable iff (rst)
        held |=> !spi_miso_oe);

    // R8: no latch command is accepted while a program cycle runs
    a_r8_busy_gate: assert property (@(posedge clk) disable iff (rst)
        (wel_set || wel_clr) |-> !$past(wr_busy));
endmodule

// File: tb/test_eeprom_cmd_engine.sv
module test_eeprom_cmd_engine;
    localparam int ADDR_W = 16;
    localparam int MEM_AW = 8;
    localparam int PAGE_W = 7;
    localparam int HALF   = 8;
    localparam int DEPTH  = 1 << MEM_AW;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2.5 clk = ~clk;

    logic              sck = 1'b0, cs_n = 1'b1, mosi = 1'b0, hold_n = 1'b1;
    logic              miso, miso_oe;
    logic              wr_busy = 1'b0;
    logic [7:0]        status_in = 8'h00;
    logic              wel_set, wel_clr, wdat_valid, wr_commit, sts_wr_valid;
    logic [ADDR_W-1:0] wdat_addr;
    logic [7:0]        wdat_byte, sts_wr_byte;
    logic              arr_we = 1'b0;
    logic [MEM_AW-1:0] arr_waddr = '0;
    logic [7:0]        arr_wdata = '0;

    eeprom_cmd_engine #(.ADDR_W(ADDR_W), .MEM_AW(MEM_AW), .PAGE_W(PAGE_W)) i_eeprom_cmd_engine (
        .clk(clk), .rst(rst),
        .spi_sck(sck), .spi_cs_n(cs_n), .spi_mosi(mosi), .spi_hold_n(hold_n),
        .spi_miso(miso), .spi_miso_oe(miso_oe),
        .wr_busy(wr_busy), .status_in(status_in),
        .wel_set(wel_set), .wel_clr(wel_clr),
        .wdat_valid(wdat_valid), .wdat_addr(wdat_addr), .wdat_byte(wdat_byte),
        .wr_commit(wr_commit), .sts_wr_valid(sts_wr_valid), .sts_wr_byte(sts_wr_byte),
        .arr_we(arr_we), .arr_waddr(arr_waddr), .arr_wdata(arr_wdata)
    );

    int n_chk = 0, n_bad = 0, cyc = 0;
    bit done = 1'b0;
    bit mode3 = 1'b0;
    logic [7:0] ref_mem [0:DEPTH-1];

    int cnt_set = 0, cnt_clr = 0, cnt_commit = 0, cnt_sts = 0, oe_cnt = 0, wq_n = 0;
    logic [7:0]        last_sts = '0;
    logic [ADDR_W-1:0] wq_a [0:15];
    logic [7:0]        wq_d [0:15];

    always @(negedge clk) begin
        if (!rst) begin
            if (wel_set) cnt_set++;
            if (wel_clr) cnt_clr++;
            if (wr_commit) cnt_commit++;
            if (sts_wr_valid) begin cnt_sts++; last_sts = sts_wr_byte; end
            if (miso_oe) oe_cnt++;
            if (wdat_valid && wq_n < 16) begin
                wq_a[wq_n] = wdat_addr;
                wq_d[wq_n] = wdat_byte;
                wq_n++;
            end
        end
    end

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    endtask

    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000 && !done) begin
            done = 1'b1;
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual=%0d cycles expected=<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [ADDR_W-1:0] page_addr(input logic [ADDR_W-1:0] a, input int k);
        logic [PAGE_W-1:0] lo;
        lo = a[PAGE_W-1:0] + PAGE_W'(k);
        return {a[ADDR_W-1:PAGE_W], lo};
    endfunction

    function automatic logic [MEM_AW-1:0] rd_index(input logic [ADDR_W-1:0] a, input int k);
        return a[MEM_AW-1:0] + MEM_AW'(k);
    endfunction

    task automatic set_mode(input bit m3);
        mode3 = m3;
        sck   = m3;
        tick(4);
    endtask

    task automatic cs_begin();
        tick(1);
        cs_n = 1'b0;
        tick(4);
    endtask

    task automatic cs_end();
        tick(HALF);
        if (!mode3) sck = 1'b0;
        tick(HALF);
        cs_n = 1'b1;
        tick(8);
    endtask

    // R9: pause with the clock low, toggle clock and data, release with clock low
    task automatic do_hold();
        hold_n = 1'b0;
        tick(6);
        for (int t = 0; t < 3; t++) begin
            sck  = 1'b1;
            mosi = 1'($urandom);
            tick(HALF);
            chk(!miso_oe, "R9 pad released while paused", 32'(miso_oe), 0);
            sck = 1'b0;
            tick(HALF);
        end
        hold_n = 1'b1;
        tick(6);
    endtask

    task automatic xfer(input logic [7:0] tx, input int hold_at,
                        output logic [7:0] rx, output bit all_oe);
        all_oe = 1'b1;
        rx     = '0;
        for (int i = 7; i >= 0; i--) begin
            if (sck) sck = 1'b0;
            tick(4);
            if (i == hold_at) do_hold();
            mosi = tx[i];
            tick(HALF - 4);
            rx[i]  = miso;
            all_oe = all_oe & miso_oe;
            sck = 1'b1;
            tick(HALF);
        end
    endtask

    task automatic read_txn(input logic [7:0] op, input logic [ADDR_W-1:0] a, input int n,
                            input int hold_byte, input int hold_bit, input string req);
        logic [7:0] rx;
        bit         oe;
        logic [7:0] exp;
        cs_begin();
        xfer(op, (hold_byte == 0) ? hold_bit : -1, rx, oe);
        xfer(a[15:8], (hold_byte == 1) ? hold_bit : -1, rx, oe);
        xfer(a[7:0], (hold_byte == 2) ? hold_bit : -1, rx, oe);
        for (int k = 0; k < n; k++) begin
            xfer(8'h00, (hold_byte == 3 + k) ? hold_bit : -1, rx, oe);
            exp = ref_mem[rd_index(a, k)];
            chk(oe && rx == exp, req, {23'd0, oe, rx}, {24'd1, exp});
        end
        cs_end();
    endtask

    task automatic write_txn(input logic [ADDR_W-1:0] a, input int n, input string req);
        logic [7:0] rx;
        bit         oe;
        logic [7:0] wd [0:7];
        int         c0;
        c0   = cnt_commit;
        wq_n = 0;
        cs_begin();
        xfer(8'h02, -1, rx, oe);
        xfer(a[15:8], -1, rx, oe);
        xfer(a[7:0], -1, rx, oe);
        for (int k = 0; k < n; k++) begin
            wd[k] = 8'($urandom);
            xfer(wd[k], -1, rx, oe);
        end
        cs_end();
        chk(wq_n == n, {req, " byte count"}, 32'(wq_n), 32'(n));
        chk(cnt_commit == c0 + 1, {req, " commit pulse"}, 32'(cnt_commit - c0), 1);
        for (int k = 0; k < n && k < wq_n; k++) begin
            chk(wq_a[k] == page_addr(a, k) && wq_d[k] == wd[k], {req, " addr/data"},
                {8'd0, wq_a[k], wq_d[k]}, {8'd0, page_addr(a, k), wd[k]});
        end
        // act as the programming unit: store the bytes
        for (int k = 0; k < wq_n; k++) begin
            arr_we    = 1'b1;
            arr_waddr = wq_a[k][MEM_AW-1:0];
            arr_wdata = wq_d[k];
            ref_mem[wq_a[k][MEM_AW-1:0]] = wq_d[k];
            tick(1);
        end
        arr_we = 1'b0;
        tick(1);
    endtask

    task automatic status_txn(input logic [7:0] sv, input string req);
        logic [7:0] rx;
        bit         oe;
        status_in = sv;
        cs_begin();
        xfer(8'h05, -1, rx, oe);
        for (int k = 0; k < 2; k++) begin
            xfer(8'h00, -1, rx, oe);
            chk(oe && rx == sv, req, {23'd0, oe, rx}, {24'd1, sv});
        end
        cs_end();
    endtask

    // sends op then three more bytes; expects a silent interface
    task automatic silent_txn(input logic [7:0] op, input string req);
        logic [7:0] rx;
        bit         oe;
        int         ev0;
        ev0    = cnt_set + cnt_clr + cnt_commit + cnt_sts + wq_n;
        oe_cnt = 0;
        cs_begin();
        xfer(op, -1, rx, oe);
        for (int k = 0; k < 3; k++) xfer(8'($urandom), -1, rx, oe);
        cs_end();
        chk(oe_cnt == 0, {req, " pad enabled"}, 32'(oe_cnt), 0);
        chk(cnt_set + cnt_clr + cnt_commit + cnt_sts + wq_n == ev0, {req, " events"},
            32'(cnt_set + cnt_clr + cnt_commit + cnt_sts + wq_n), 32'(ev0));
    endtask

    initial begin
        logic [7:0] rx;
        bit         oe;
        int         s0;
        void'($urandom(32'h5EED_1234));
        tick(6);
        rst = 1'b0;
        tick(4);
        // R10: reset state
        chk(!miso_oe, "R10 reset pad released", 32'(miso_oe), 0);
        chk(cnt_set + cnt_clr + cnt_commit + cnt_sts == 0, "R10 reset no events",
            32'(cnt_set + cnt_clr + cnt_commit + cnt_sts), 0);

        for (int i = 0; i < DEPTH; i++) begin
            arr_we    = 1'b1;
            arr_waddr = MEM_AW'(i);
            arr_wdata = 8'($urandom);
            ref_mem[i] = arr_wdata;
            tick(1);
        end
        arr_we = 1'b0;
        tick(2);

        // R10: clock and data toggling while deselected
        oe_cnt = 0;
        for (int i = 0; i < 16; i++) begin
            mosi = 1'($urandom); sck = ~sck; tick(HALF);
        end
        sck = 1'b0; tick(4);
        chk(oe_cnt == 0 && cnt_set + cnt_clr + cnt_sts + wq_n == 0,
            "R10 deselected activity ignored", 32'(oe_cnt), 0);

        // R3: plain read, mode 0
        set_mode(1'b0);
        read_txn(8'h03, 16'h0010, 4, -1, -1, "R3 read mode0");
        // R1: bit 3 ignored, mode 3
        set_mode(1'b1);
        read_txn(8'h0B, 16'h0040, 3, -1, -1, "R1 read with bit3 set mode3");
        // R3: wrap at top of array, upper address bits ignored
        set_mode(1'b0);
        read_txn(8'h03, 16'hABFE, 4, -1, -1, "R3 wrap past last location");

        // R4: status read repeats
        status_txn(8'hA5, "R4 status read");
        set_mode(1'b1);
        status_txn(8'h3C, "R4 status read mode3");
        set_mode(1'b0);

        // R7: latch commands
        s0 = cnt_set;
        cs_begin(); xfer(8'h06, -1, rx, oe); cs_end();
        chk(cnt_set == s0 + 1, "R7 latch-set pulse", 32'(cnt_set - s0), 1);
        s0 = cnt_clr;
        cs_begin(); xfer(8'h0C, -1, rx, oe); cs_end();
        chk(cnt_clr == s0 + 1, "R7 latch-clear pulse (bit3 set)", 32'(cnt_clr - s0), 1);

        // R5: page-wrapped write, then read back
        write_txn(16'h127E, 4, "R5 write across page end");
        read_txn(8'h03, 16'h127E, 2, -1, -1, "R5 readback");
        read_txn(8'h03, 16'h1200, 2, -1, -1, "R5 readback wrapped part");

        // R6: status write, extra byte ignored
        s0 = cnt_sts;
        cs_begin(); xfer(8'h01, -1, rx, oe); xfer(8'h8C, -1, rx, oe); xfer(8'h77, -1, rx, oe); cs_end();
        chk(cnt_sts == s0 + 1 && last_sts == 8'h8C, "R6 status write byte",
            {16'd0, 8'(cnt_sts - s0), last_sts}, {16'd0, 8'd1, 8'h8C});

        // R2: invalid commands freeze, then recovery
        silent_txn(8'h07, "R2 invalid low bits 111");
        silent_txn(8'h00, "R2 invalid low bits 000");
        silent_txn(8'h13, "R2 invalid upper nibble");
        read_txn(8'h03, 16'h0020, 2, -1, -1, "R2 recovery after freeze");

        // R8: busy blocks all but status read
        wr_busy = 1'b1;
        silent_txn(8'h03, "R8 read while busy");
        silent_txn(8'h06, "R8 latch-set while busy");
        silent_txn(8'h02, "R8 write while busy");
        status_txn(8'h81, "R8 status read while busy");
        wr_busy = 1'b0;

        // R9: pause in address phase and in data phase, both modes
        read_txn(8'h03, 16'h0033, 2, 1, 4, "R9 pause in address");
        read_txn(8'h03, 16'h0050, 3, 4, 3, "R9 pause in data");
        set_mode(1'b1);
        read_txn(8'h03, 16'h00F0, 2, 3, 6, "R9 pause in data mode3");

        // random reads mixed with pauses
        for (int r = 0; r < 20; r++) begin
            logic [ADDR_W-1:0] a;
            int n, hb, hbit;
            set_mode(1'($urandom));
            a    = ADDR_W'($urandom);
            n    = 1 + int'($urandom % 4);
            hb   = (($urandom % 4) == 0) ? int'($urandom % (3 + n)) : -1;
            hbit = int'($urandom % 8);
            read_txn((($urandom % 2) == 0) ? 8'h03 : 8'h0B, a, n, hb, hbit, "R3 random read");
        end
        // random writes with readback
        for (int r = 0; r < 6; r++) begin
            logic [ADDR_W-1:0] a;
            int n;
            set_mode(1'($urandom));
            a = ADDR_W'($urandom);
            n = 1 + int'($urandom % 4);
            write_txn(a, n, "R5 random write");
            read_txn(8'h03, a, 1, -1, -1, "R5 random readback");
        end

        done = 1'b1;
        summary();
        $finish;
    end
endmodule